// File: doc/BRIEF.md
# Cell Overcharge Confirmation Supervisor

This block watches one lithium cell through a digitized voltage code in millivolts. It decides when the cell is overcharged and drives the gate-control line of a charge-blocking transistor. A voltage above the programmed trip level must persist for a chosen number of timebase ticks before the block commits to the overcharge state. The block leaves that state as soon as the voltage falls under a lower release level, which lies a programmable hysteresis below the trip level.

The output line can be configured for either polarity. It can also be configured for push-pull or open-drain drive; in open-drain form the enable is dropped whenever the line should read high. A test input, held low, divides the confirmation delay by 64 so that production test does not have to wait whole seconds. All configuration is captured only while no overcharge is declared, so a configuration change cannot alter an active protection event.

Top module: `ovp_delay_ctrl`

## Requirements
- R1: The trip level in mV is 3500 + 5 × min(trip_code, 300). The delay counter advances only on a tick while cell_mv is strictly greater than the trip level.
- R2: The release level is the trip level minus 50 × (hyst_code + 1) mV. In the overcharge state, the first clock edge that sees cell_mv strictly below the release level returns the block to normal. Any value at or above the release level keeps it in overcharge.
- R3: With test_n high, the delay is TICKS_PER_SEC ticks for delay_sel 00, 2× for 01, and 4× for 10 or 11. The block enters overcharge at the edge of the tick that brings the count to that value.
- R4: With test_n low, the delay is the R3 value shifted right by 6 bits, with a floor of one tick.
- R5: A clock edge seen in the normal state with cell_mv at or below the trip level clears the delay count, so a later overcharge needs the full delay again.
- R6: With act_high = 1, the logical output is 1 in overcharge and 0 in normal. With act_high = 0, it is 0 in overcharge and 1 in normal.
- R7: With open_drain = 0, co_oe is 1 and co_level equals the logical output. With open_drain = 1, co_level is 0 and co_oe is 1 only when the logical output is 0.
- R8: trip_code, hyst_code, delay_sel, act_high and open_drain are captured on every clock edge in the normal state and held unchanged in overcharge. A captured value takes effect one edge after capture.
- R9: A synchronous reset forces the normal state, clears the delay count and captures the configuration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tick | input | 1 | Timebase pulse, one clock wide per tick |
| cell_mv | input | VW | Cell voltage code in mV |
| trip_code | input | 9 | Trip level step code |
| hyst_code | input | 3 | Hysteresis step code |
| delay_sel | input | 2 | Confirmation delay select |
| test_n | input | 1 | Delay compression when low |
| act_high | input | 1 | Output polarity select |
| open_drain | input | 1 | Output form select |
| co_level | output | 1 | Charge-control output level |
| co_oe | output | 1 | Charge-control output drive enable |

## Verification
The hardest case to reach is the exact trip and release boundary for every trip code and hysteresis pair. At full delay, each attempt at a trip costs hundreds of ticks. The stimulus holds test_n low with the shortest delay, which makes one tick enough to confirm. Every code from 0 to 511 is then crossed with every hysteresis step, probing trip level and trip level + 1, then release level and release level − 1. The full-length delays, including a count aborted one tick before it expires, are checked separately with a handful of settings.

// File: rtl/ovp_delay_ctrl.sv
module ovp_delay_ctrl #(
  parameter int VW            = 13,
  parameter int TICKS_PER_SEC = 1024
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick,
  input  logic [VW-1:0] cell_mv,
  input  logic [8:0]    trip_code,
  input  logic [2:0]    hyst_code,
  input  logic [1:0]    delay_sel,
  input  logic          test_n,
  input  logic          act_high,
  input  logic          open_drain,
  output logic          co_level,
  output logic          co_oe
);
  localparam int CW        = $clog2(4 * TICKS_PER_SEC + 1);
  localparam int TRIP_BASE = 3500;
  localparam int TRIP_STEP = 5;
  localparam int TRIP_MAX  = 300;
  localparam int HYST_STEP = 50;
  localparam int FAST_SH   = 6;

  typedef enum logic {ST_NORM = 1'b0, ST_OVER = 1'b1} st_t;

  st_t           st_q;
  logic [CW-1:0] cnt_q;
  logic [8:0]    trip_q;
  logic [2:0]    hyst_q;
  logic [1:0]    dsel_q;
  logic          pol_q, od_q;

  logic [8:0]    trip_eff;
  logic [VW-1:0] trip_mv, rel_mv;
  logic          above, below;
  logic [CW-1:0] term_nom, term_fast, term, cnt_nx;
  logic          lvl;

  assign trip_eff = (trip_q > 9'(TRIP_MAX)) ? 9'(TRIP_MAX) : trip_q;
  assign trip_mv  = VW'(TRIP_BASE) + VW'(TRIP_STEP) * VW'(trip_eff);
  assign rel_mv   = trip_mv - VW'(HYST_STEP) * (VW'(hyst_q) + VW'(1));
  assign above    = cell_mv > trip_mv;
  assign below    = cell_mv < rel_mv;

  always_comb begin
    case (dsel_q)
      2'b00:   term_nom = CW'(TICKS_PER_SEC);
      2'b01:   term_nom = CW'(2 * TICKS_PER_SEC);
      default: term_nom = CW'(4 * TICKS_PER_SEC);
    endcase
  end

  assign term_fast = term_nom >> FAST_SH;
  assign term      = !test_n ? ((term_fast == '0) ? CW'(1) : term_fast) : term_nom;
  assign cnt_nx    = cnt_q + CW'(1);

  always_ff @(posedge clk) begin
    if (rst || st_q == ST_NORM) begin
      trip_q <= trip_code;
      hyst_q <= hyst_code;
      dsel_q <= delay_sel;
      pol_q  <= act_high;
      od_q   <= open_drain;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q  <= ST_NORM;
      cnt_q <= '0;
    end else begin
      case (st_q)
        ST_NORM: begin
          if (!above) begin
            cnt_q <= '0;
          end else if (tick) begin
            if (cnt_nx >= term) begin
              st_q  <= ST_OVER;
              cnt_q <= '0;
            end else begin
              cnt_q <= cnt_nx;
            end
          end
        end
        default: begin
          if (below) st_q <= ST_NORM;
        end
      endcase
    end
  end

  assign lvl      = pol_q ? (st_q == ST_OVER) : (st_q != ST_OVER);
  assign co_level = od_q ? 1'b0 : lvl;
  assign co_oe    = od_q ? !lvl : 1'b1;
endmodule

module ovp_delay_ctrl_chk #(
  parameter int VW = 13,
  parameter int CW = 13
) (
  input logic          clk,
  input logic          rst,
  input logic          tick,
  input logic          over,
  input logic          above,
  input logic          below,
  input logic [CW-1:0] cnt,
  input logic [15:0]   cfg,
  input logic          od,
  input logic          co_level
);
  a_r9_reset_clears: assert property (@(posedge clk) rst |=> (!over && cnt == '0));
  a_r3_entry_on_tick: assert property (@(posedge clk) disable iff (rst)
    $rose(over) |-> ($past(tick) && $past(above)));
  a_r1_entry_above_trip: assert property (@(posedge clk) disable iff (rst)
    $rose(over) |-> $past(above));
  a_r2_exit_below_release: assert property (@(posedge clk) disable iff (rst)
    ($fell(over) && !$past(rst)) |-> $past(below));
  a_r5_count_cleared: assert property (@(posedge clk) disable iff (rst)
    ($past(!over) && $past(!above)) |-> cnt == '0);
  a_r8_cfg_frozen: assert property (@(posedge clk) disable iff (rst)
    (over && $past(over)) |-> $stable(cfg));
  a_r7_od_never_high: assert property (@(posedge clk) disable iff (rst)
    od |-> !co_level);
endmodule

bind ovp_delay_ctrl ovp_delay_ctrl_chk #(.VW(VW), .CW(CW)) u_chk (
  .clk(clk), .rst(rst), .tick(tick), .over(st_q == ST_OVER),
  .above(above), .below(below), .cnt(cnt_q),
  .cfg({trip_q, hyst_q, dsel_q, pol_q, od_q}), .od(od_q), .co_level(co_level)
);

// File: tb/ovp_delay_ctrl_tb.sv
module ovp_delay_ctrl_tb;
  localparam int TPS = 64;
  localparam int VW  = 13;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic          rst = 1'b1, tick = 1'b0, test_n = 1'b1, act_high = 1'b1, open_drain = 1'b0;
  logic [VW-1:0] cell_mv = '0;
  logic [8:0]    trip_code = '0;
  logic [2:0]    hyst_code = '0;
  logic [1:0]    delay_sel = '0;
  logic          co_level, co_oe;

  int n_run = 0, n_fail = 0;
  bit done = 0;
  bit pol_m = 1, od_m = 0;

  ovp_delay_ctrl #(.VW(VW), .TICKS_PER_SEC(TPS)) u_dut (
    .clk(clk), .rst(rst), .tick(tick), .cell_mv(cell_mv), .trip_code(trip_code),
    .hyst_code(hyst_code), .delay_sel(delay_sel), .test_n(test_n),
    .act_high(act_high), .open_drain(open_drain), .co_level(co_level), .co_oe(co_oe)
  );

  task automatic check(input string req, input int act, input int exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #2;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      tick = 1'b1;
      step();
    end
    tick = 1'b0;
  endtask

  task automatic chk_out(input string req, input bit over);
    bit lvl;
    lvl = pol_m ? over : !over;
    check({req, " level"}, int'(co_level), od_m ? 0 : int'(lvl));
    check({req, " oe"}, int'(co_oe), od_m ? int'(!lvl) : 1);
  endtask

  function automatic int trip_of(input int c);
    return 3500 + 5 * ((c > 300) ? 300 : c);
  endfunction

  function automatic int nom_of(input int s);
    return (s == 0) ? TPS : (s == 1) ? 2 * TPS : 4 * TPS;
  endfunction

  initial begin
    int tr, rl, tm;
    // R9 reset state
    cell_mv = 13'd3000;
    step(); step();
    chk_out("R9 reset", 0);
    rst = 1'b0;
    step();

    // R1 R2 R4 sweep of all codes and hysteresis steps with a one-tick delay
    test_n = 1'b0;
    delay_sel = 2'b00;
    for (int c = 0; c < 512; c++) begin
      for (int h = 0; h < 8; h++) begin
        tr = trip_of(c);
        rl = tr - 50 * (h + 1);
        cell_mv = 13'd3000; trip_code = 9'(c); hyst_code = 3'(h);
        step();
        cell_mv = VW'(tr); ticks(1);
        chk_out("R1 at trip", 0);
        cell_mv = VW'(tr + 1); ticks(1);
        chk_out("R1 R4 above trip", 1);
        cell_mv = VW'(rl); step();
        chk_out("R2 at release", 1);
        cell_mv = VW'(rl - 1); step();
        chk_out("R2 below release", 0);
      end
    end

    // R3 R4 delay lengths
    trip_code = 9'd100; hyst_code = 3'd0;
    for (int t = 0; t < 2; t++) begin
      for (int s = 0; s < 4; s++) begin
        cell_mv = 13'd3000; test_n = t[0]; delay_sel = 2'(s);
        step();
        tm = nom_of(s);
        if (t == 0) tm = (tm >> 6 == 0) ? 1 : tm >> 6;
        cell_mv = 13'd4100;
        if (tm > 1) begin
          ticks(tm - 1);
          step(); step();
          chk_out(t ? "R3 before expiry" : "R4 before expiry", 0);
        end
        ticks(1);
        chk_out(t ? "R3 at expiry" : "R4 at expiry", 1);
        cell_mv = 13'd3000; step();
      end
    end

    // R5 abort one tick short
    test_n = 1'b1; delay_sel = 2'b00; cell_mv = 13'd3000; step();
    cell_mv = 13'd4100; ticks(TPS - 1);
    cell_mv = 13'd4000; step();
    cell_mv = 13'd4100; ticks(TPS - 1);
    chk_out("R5 restart after abort", 0);
    ticks(1);
    chk_out("R5 full delay after abort", 1);
    cell_mv = 13'd3000; step();

    // R6 R7 polarity and form
    test_n = 1'b0;
    for (int p = 0; p < 2; p++) begin
      for (int o = 0; o < 2; o++) begin
        act_high = p[0]; open_drain = o[0];
        cell_mv = 13'd3000; step();
        pol_m = p[0]; od_m = o[0];
        chk_out("R6 R7 normal", 0);
        cell_mv = 13'd4100; ticks(1);
        chk_out("R6 R7 over", 1);
        cell_mv = 13'd3000; step();
        chk_out("R6 R7 released", 0);
      end
    end

    // R8 configuration frozen during overcharge
    act_high = 1'b1; open_drain = 1'b0; trip_code = 9'd100; hyst_code = 3'd0;
    step(); pol_m = 1; od_m = 0;
    cell_mv = 13'd4100; ticks(1);
    chk_out("R8 enter", 1);
    act_high = 1'b0; open_drain = 1'b1; trip_code = 9'd0; hyst_code = 3'd7;
    cell_mv = 13'd3950; step(); step();
    chk_out("R8 held output", 1);
    cell_mv = 13'd3949; step();
    chk_out("R8 old release level", 0);
    step();
    pol_m = 0; od_m = 1;
    chk_out("R8 new config after release", 0);

    // R9 reset during overcharge
    act_high = 1'b1; open_drain = 1'b0; trip_code = 9'd100; hyst_code = 3'd0;
    step(); pol_m = 1; od_m = 0;
    cell_mv = 13'd4100; ticks(1);
    chk_out("R9 pre", 1);
    rst = 1'b1; step(); rst = 1'b0;
    chk_out("R9 reset in overcharge", 0);
    test_n = 1'b1; ticks(TPS - 1);
    chk_out("R9 count cleared", 0);
    ticks(1);
    chk_out("R9 full delay after reset", 1);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: got 0 expected 1");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule